// File: doc/BRIEF.md
# CAN Channel Mode Controller

This block sits between a CAN protocol engine and the physical bus lines and decides how the two are joined. A two-bit mode request selects one of three operating modes. In enabled mode the block passes bits straight through in both directions. In standby mode it parks the transmit pin at the recessive level, turns the receiver off and shows the engine a steady recessive bit. In listening mode it loops the engine's own transmit bit back to its receive input. The pin stays recessive and the receive path stays enabled.

The block also holds the transmit and receive error counters. The engine reports error and success events on single-cycle strobes. The counters follow those strobes, except in listening mode, where they are frozen. A new mode request is taken only on a bit-boundary strobe from the engine, so that a bit on the wire is never cut short. All pins are plain control signals: there is no stream data and no back-pressure, so the block has no valid/ready interface.

Top module: `can_mode_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the active mode is standby, and both error counters read zero.
- R2: In enabled mode, `tx_pin` equals `eng_tx`, `eng_rx` equals `rx_pin`, and `rx_enable` is 1. All three are combinational from the current inputs.
- R3: In standby mode, `tx_pin` is 1 (recessive), `eng_rx` is 1 and `rx_enable` is 0, whatever values `eng_tx` and `rx_pin` take.
- R4: In listening mode, `tx_pin` is 1, `eng_rx` equals `eng_tx` (loopback), and `rx_enable` stays 1.
- R5: In listening mode, the counter strobes `tec_inc`, `tec_dec`, `rec_inc` and `rec_dec` have no effect, so both counters keep their values.
- R6: Outside listening mode, `tec_inc` adds TEC_STEP (default 8) and `rec_inc` adds REC_STEP (default 1). Each dec strobe subtracts 1. When inc and dec arrive in the same cycle, the increment is applied and the decrement is dropped.
- R7: The counters saturate. An increment that would pass 2^CNT_W-1 leaves the counter at 2^CNT_W-1, and a decrement at 0 leaves it at 0.
- R8: `mode_req` is sampled only on a clock edge where `bit_tick` is 1, and the new mode shows on `active_mode` after that edge. Without `bit_tick` the mode holds.
- R9: The mode codes are 00 enabled, 01 standby and 10 listening. The code 11 is decoded as standby, so `active_mode` never reads 11.
- R10: A counter strobe is gated by the mode that is active at the clock edge where the strobe is sampled, not by the mode being loaded on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_req | input | 2 | Requested mode code |
| bit_tick | input | 1 | Bit-boundary strobe from the engine |
| eng_tx | input | 1 | Engine transmit bit |
| rx_pin | input | 1 | Physical receive pin |
| tec_inc | input | 1 | Transmit error event |
| tec_dec | input | 1 | Transmit success event |
| rec_inc | input | 1 | Receive error event |
| rec_dec | input | 1 | Receive success event |
| tx_pin | output | 1 | Physical transmit pin |
| eng_rx | output | 1 | Receive bit presented to the engine |
| rx_enable | output | 1 | Receiver enable to the engine |
| active_mode | output | 2 | Mode currently in force |
| tec | output | CNT_W | Transmit error counter |
| rec | output | CNT_W | Receive error counter |

## Verification
The bench builds the block with the default parameters: CNT_W of 8, TEC_STEP of 8 and REC_STEP of 1. With these values the transmit counter reaches its ceiling after 32 error strobes and the receive counter after 255, so both saturation limits and the underflow floor are reached in a short run. TEC_STEP of 8 does not divide 255 evenly, so the final transmit increment is clipped rather than landing exactly on the limit, and the clipping path is exercised. The bench also sends strobes in the same cycle as a mode change, which separates the old-mode gating from the new-mode gating.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    MODE_ENABLED = 2'b00,
    MODE_STANDBY = 2'b01,
    MODE_LISTEN  = 2'b10,
    MODE_RSVD    = 2'b11
  } chan_mode_e;

  // Reserved code falls back to the safe, bus-quiet mode.
  function automatic chan_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'b00:   decode_mode = MODE_ENABLED;
      2'b10:   decode_mode = MODE_LISTEN;
      default: decode_mode = MODE_STANDBY;
    endcase
  endfunction

endpackage

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_req,
  input  logic       bit_tick,
  output chan_mode_e mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STANDBY;
    end else if (bit_tick) begin
      mode_q <= decode_mode(mode_req);
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(mode_q)); // R8

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && mode_req != 2'b11) |=> (mode_q == $past(mode_req))); // R8

  AST_MODE_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && mode_req == 2'b11) |=> (mode_q == MODE_STANDBY)); // R9

endmodule

// File: rtl/can_line_mux.sv
module can_line_mux
  import can_mode_pkg::*;
(
  input  chan_mode_e mode,
  input  logic       eng_tx,
  input  logic       rx_pin,
  output logic       tx_pin,
  output logic       eng_rx,
  output logic       rx_enable
);

  localparam logic RECESSIVE = 1'b1;

  always_comb begin
    tx_pin    = RECESSIVE;
    eng_rx    = RECESSIVE;
    rx_enable = 1'b0;
    case (mode)
      MODE_ENABLED: begin
        tx_pin    = eng_tx;
        eng_rx    = rx_pin;
        rx_enable = 1'b1;
      end
      MODE_LISTEN: begin
        eng_rx    = eng_tx;
        rx_enable = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/can_err_cnt.sv
module can_err_cnt #(
  parameter int CNT_W    = 8,
  parameter int INC_STEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] STEP_V   = CNT_W'(INC_STEP);
  localparam logic [CNT_W-1:0] INC_LIM  = CNT_MAX - STEP_V;

  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt;
    if (cnt_en) begin
      if (inc) begin
        cnt_nx = (cnt > INC_LIM) ? CNT_MAX : cnt + STEP_V;
      end else if (dec) begin
        cnt_nx = (cnt == '0) ? '0 : cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end

  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt)); // R5

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && inc && cnt <= INC_LIM) |=> (cnt == $past(cnt) + STEP_V)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && inc && cnt > INC_LIM) |=> (cnt == CNT_MAX)); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && dec && !inc && cnt == '0) |=> (cnt == '0)); // R7

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int TEC_STEP = 8,
  parameter int REC_STEP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_req,
  input  logic             bit_tick,
  input  logic             eng_tx,
  input  logic             rx_pin,
  input  logic             tec_inc,
  input  logic             tec_dec,
  input  logic             rec_inc,
  input  logic             rec_dec,
  output logic             tx_pin,
  output logic             eng_rx,
  output logic             rx_enable,
  output logic [1:0]       active_mode,
  output logic [CNT_W-1:0] tec,
  output logic [CNT_W-1:0] rec
);

  chan_mode_e mode_q;
  logic       cnt_en;

  can_mode_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_req (mode_req),
    .bit_tick (bit_tick),
    .mode_q   (mode_q)
  );

  can_line_mux u_mux (
    .mode      (mode_q),
    .eng_tx    (eng_tx),
    .rx_pin    (rx_pin),
    .tx_pin    (tx_pin),
    .eng_rx    (eng_rx),
    .rx_enable (rx_enable)
  );

  // Counters follow the mode in force before the edge (R10).
  assign cnt_en = (mode_q != MODE_LISTEN);

  can_err_cnt #(.CNT_W(CNT_W), .INC_STEP(TEC_STEP)) u_tec (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .inc    (tec_inc),
    .dec    (tec_dec),
    .cnt    (tec)
  );

  can_err_cnt #(.CNT_W(CNT_W), .INC_STEP(REC_STEP)) u_rec (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .inc    (rec_inc),
    .dec    (rec_dec),
    .cnt    (rec)
  );

  assign active_mode = mode_q;

  AST_ENABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mode == 2'b00) |-> (tx_pin == eng_tx && eng_rx == rx_pin && rx_enable)); // R2

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mode == 2'b01) |-> (tx_pin && eng_rx && !rx_enable)); // R3

  AST_LISTEN_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mode == 2'b10) |-> (tx_pin && rx_enable && eng_rx == eng_tx)); // R4

  AST_LISTEN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mode == 2'b10) |=> ($stable(tec) && $stable(rec))); // R5

  AST_MODE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    active_mode != 2'b11); // R9

endmodule

// File: tb/test_can_mode_ctrl.sv
module test_can_mode_ctrl;

  localparam int CNT_W    = 8;
  localparam int TEC_STEP = 8;
  localparam int REC_STEP = 1;
  localparam int CMAX     = (1 << CNT_W) - 1;

  localparam logic [1:0] C_EN = 2'b00;
  localparam logic [1:0] C_SB = 2'b01;
  localparam logic [1:0] C_LI = 2'b10;
  localparam logic [1:0] C_RS = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_req = 2'b00;
  logic bit_tick = 1'b0, eng_tx = 1'b1, rx_pin = 1'b1;
  logic tec_inc = 1'b0, tec_dec = 1'b0, rec_inc = 1'b0, rec_dec = 1'b0;
  logic tx_pin, eng_rx, rx_enable;
  logic [1:0] active_mode;
  logic [CNT_W-1:0] tec, rec;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       tx;
    logic       rx;
    logic       rxen;
    logic [1:0] mode;
    int         tec;
    int         rec;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  logic [1:0] m_mode = C_SB;
  int m_tec = 0;
  int m_rec = 0;

  always #10 clk = ~clk; // 50 MHz

  can_mode_ctrl #(.CNT_W(CNT_W), .TEC_STEP(TEC_STEP), .REC_STEP(REC_STEP)) i_can_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .bit_tick(bit_tick),
    .eng_tx(eng_tx), .rx_pin(rx_pin), .tec_inc(tec_inc), .tec_dec(tec_dec),
    .rec_inc(rec_inc), .rec_dec(rec_dec), .tx_pin(tx_pin), .eng_rx(eng_rx),
    .rx_enable(rx_enable), .active_mode(active_mode), .tec(tec), .rec(rec)
  );

  function automatic logic [1:0] ref_decode(input logic [1:0] c);
    if (c == C_EN) return C_EN;
    if (c == C_LI) return C_LI;
    return C_SB;
  endfunction

  function automatic int ref_cnt(input int v, input bit inc, input bit dec, input int step);
    if (inc) return (v + step > CMAX) ? CMAX : v + step;
    if (dec) return (v == 0) ? 0 : v - 1;
    return v;
  endfunction

  // Driver: apply one cycle of stimulus and push the expected post-edge view.
  task automatic step(input logic [1:0] req, input bit tick, input bit etx, input bit rxp,
                      input bit ti, input bit td, input bit ri, input bit rd, input string tag);
    exp_t e;
    @(negedge clk);
    mode_req = req; bit_tick = tick; eng_tx = etx; rx_pin = rxp;
    tec_inc = ti; tec_dec = td; rec_inc = ri; rec_dec = rd;
    if (m_mode != C_LI) begin
      m_tec = ref_cnt(m_tec, ti, td, TEC_STEP);
      m_rec = ref_cnt(m_rec, ri, rd, REC_STEP);
    end
    if (tick) m_mode = ref_decode(req);
    e.mode = m_mode;
    e.tec  = m_tec;
    e.rec  = m_rec;
    e.tag  = tag;
    case (m_mode)
      C_EN:    begin e.tx = etx;  e.rx = rxp;  e.rxen = 1'b1; end
      C_LI:    begin e.tx = 1'b1; e.rx = etx;  e.rxen = 1'b1; end
      default: begin e.tx = 1'b1; e.rx = 1'b1; e.rxen = 1'b0; end
    endcase
    sb_q.push_back(e);
  endtask

  // Monitor: sample mid-cycle, after the edge that the item belongs to.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (tx_pin !== e.tx || eng_rx !== e.rx || rx_enable !== e.rxen ||
            active_mode !== e.mode || int'(tec) != e.tec || int'(rec) != e.rec) begin
          errors++;
          $display("FAIL %s: actual tx=%b rx=%b rxen=%b mode=%b tec=%0d rec=%0d expected tx=%b rx=%b rxen=%b mode=%b tec=%0d rec=%0d",
                   e.tag, tx_pin, eng_rx, rx_enable, active_mode, tec, rec,
                   e.tx, e.rx, e.rxen, e.mode, e.tec, e.rec);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual run still going, expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while held, with pins driven away from recessive
    eng_tx = 1'b0; rx_pin = 1'b0;
    #1;
    checks++;
    if (active_mode !== C_SB || tec !== '0 || rec !== '0 || tx_pin !== 1'b1) begin
      errors++;
      $display("FAIL R1: actual mode=%b tec=%0d rec=%0d tx=%b expected mode=01 tec=0 rec=0 tx=1",
               active_mode, tec, rec, tx_pin);
    end
    @(negedge clk);
    rst_n = 1'b1;

    step(C_EN, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R8: request without bit_tick is not taken; R3 standby quiet
    step(C_EN, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(C_EN, 0, 1, 0, 0, 0, 0, 0, "R3");
    step(C_EN, 0, 0, 1, 0, 0, 0, 0, "R3");
    // R6 counters also run in standby
    step(C_EN, 0, 1, 1, 1, 0, 1, 0, "R6");
    // R8: tick loads enabled
    step(C_EN, 1, 0, 1, 0, 0, 0, 0, "R8");
    // R2 pass-through patterns
    step(C_SB, 0, 0, 1, 0, 0, 0, 0, "R2");
    step(C_SB, 0, 1, 0, 0, 0, 0, 0, "R2");
    step(C_SB, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(C_SB, 0, 1, 1, 0, 0, 0, 0, "R2");
    // R6 increments, decrements, simultaneous
    step(C_EN, 0, 1, 1, 1, 0, 0, 0, "R6");
    step(C_EN, 0, 1, 1, 1, 0, 1, 0, "R6");
    step(C_EN, 0, 1, 1, 0, 1, 0, 1, "R6");
    step(C_EN, 0, 1, 1, 1, 1, 1, 1, "R6");
    step(C_EN, 0, 1, 1, 0, 0, 1, 0, "R6");
    // R10: strobes on the edge that loads listen still count
    step(C_LI, 1, 1, 1, 1, 0, 1, 0, "R10");
    // R4 loopback patterns with rx_pin opposite
    step(C_LI, 0, 0, 1, 0, 0, 0, 0, "R4");
    step(C_LI, 0, 1, 0, 0, 0, 0, 0, "R4");
    step(C_LI, 0, 0, 0, 0, 0, 0, 0, "R4");
    // R5 events ignored in listen
    step(C_LI, 0, 1, 1, 1, 0, 1, 0, "R5");
    step(C_LI, 0, 1, 1, 0, 1, 0, 1, "R5");
    step(C_LI, 0, 1, 1, 1, 1, 1, 1, "R5");
    // R10: strobes on edge leaving listen are still ignored
    step(C_EN, 1, 1, 1, 1, 0, 1, 0, "R10");
    step(C_EN, 0, 1, 1, 0, 0, 0, 0, "R10");
    // R9 reserved code decodes to standby
    step(C_RS, 1, 0, 0, 0, 0, 0, 0, "R9");
    step(C_RS, 0, 0, 0, 0, 0, 0, 0, "R9");
    step(C_EN, 1, 1, 1, 0, 0, 0, 0, "R8");
    // R7 saturate tec upward
    for (int i = 0; i < 34; i++) step(C_EN, 0, 1, 1, 1, 0, 0, 0, "R7");
    // R7 saturate rec upward
    for (int i = 0; i < 258; i++) step(C_EN, 0, 1, 1, 0, 0, 1, 0, "R7");
    // R7 drain to zero and past it
    for (int i = 0; i < 258; i++) step(C_EN, 0, 1, 1, 0, 1, 0, 1, "R7");
    step(C_EN, 0, 1, 1, 0, 1, 0, 1, "R7");

    wait (sb_q.size() == 0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule